// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block is a tags-only model of a tiny cache of four one-word blocks. It accepts one block-address reference per cycle on a strobe, decides whether the reference hits the cache, and labels every miss with the reason it happened. A miss is compulsory if the address was never referenced before. It is a conflict miss if a fully associative cache of the same size would have hit. Any other miss is a capacity miss. The main cache's associativity is fixed at build time: direct-mapped, 2-way, or a single fully associative set. Replacement inside a set is least recently used.

To classify the misses, the block runs a fully associative LRU shadow cache of four entries next to the main cache. It also keeps a bitmap that records every address ever referenced. Each reference is judged against the state that the previous reference left behind, and both structures are updated in the same cycle. The result is registered one cycle after the strobe. Four saturating counters accumulate the miss totals. The block is meant for measuring reference streams, for example to show how the miss mix moves as associativity changes. It holds no data, has no refill path and has no write policy.

Top module: `miss_classifier`

## Requirements
- R1: After a synchronous reset, which is active high on `rst`, every cache entry is invalid and no address counts as referenced. `res_hit`, `res_miss`, `res_type` and all four counters read zero.
- R2: The number of ways is set by `WAYS`, which may be 1, 2 or 4. The number of sets is 4/WAYS. A reference selects set (address mod sets), so with WAYS=1, addresses 1 and 5 compete for the same block while 1 and 2 do not.
- R3: A reference hits when the selected set holds a valid entry whose stored tag equals the address. The result then shows `res_hit`=1, `res_miss`=0 and `res_type`=00.
- R4: A miss replaces the least recently used entry of the selected set, where both hits and fills count as uses. With WAYS=2, the stream 0, 2, 0, 4, 2 hits only on the third reference.
- R5: A miss on an address that was never referenced since reset gives `res_type`=01 (compulsory).
- R6: A miss on an address seen before, which the four-entry fully associative LRU shadow cache would have hit, gives `res_type`=11 (conflict). The shadow cache updates its LRU order on every reference, and it is consulted before that update.
- R7: Any other miss gives `res_type`=10 (capacity).
- R8: The result appears on the outputs in the cycle after the strobe. In a cycle after no strobe, `res_hit`=`res_miss`=0 and `res_type`=00. Back-to-back strobes are each classified against the state left by the previous reference.
- R9: `cnt_total` counts misses. `cnt_comp`, `cnt_cap` and `cnt_conf` count the misses of each type. Each counter is CNT_W bits wide (16 by default), stops at its all-ones value, and changes in the same cycle as the result it counts.
- R10: After reset, the stream 0, 8, 0, 6, 8 gives these counts: with WAYS=1, total 5, compulsory 3, conflict 2; with WAYS=2, total 4, compulsory 3, conflict 1; with WAYS=4, total 3, all compulsory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_stb | input | 1 | A reference is present this cycle |
| ref_addr | input | ADDR_W | Block address of the reference |
| res_hit | output | 1 | Previous-cycle reference hit |
| res_miss | output | 1 | Previous-cycle reference missed |
| res_type | output | 2 | Miss kind: 00 none, 01 compulsory, 10 capacity, 11 conflict |
| cnt_total | output | CNT_W | Saturating count of all misses |
| cnt_comp | output | CNT_W | Saturating count of compulsory misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |

## Verification
Suppose a tag, valid bit, LRU age or seen bit goes wrong. The error stays hidden until a later reference maps onto that entry, and then it appears one cycle after that reference as a wrong hit or miss, or as a wrong miss type. A stale LRU order shows up only after two or more further references to the same set, so the reference model is compared on every clock across all three associativities, using streams that revisit sets. The counters are checked at the same cycle as each result, so a miscount is caught at once and not only at the end of the stream.

// File: rtl/mc_pkg.sv
package mc_pkg;
    typedef enum logic [1:0] {
        MT_NONE = 2'b00,
        MT_COMP = 2'b01,
        MT_CAP  = 2'b10,
        MT_CONF = 2'b11
    } miss_kind_e;
endpackage

// File: rtl/mc_set_cache.sv
// Tags-only set-associative cache with per-way LRU ages.
// The ages within a set form a permutation: 0 is the most recently used.
// Invalid ways always carry the largest ages, so the victim is simply the oldest way.
module mc_set_cache #(
    parameter int ADDR_W = 8,
    parameter int WAYS   = 2,
    parameter int SETS   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              hit
);
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]              vld;
        logic [SETS-1:0][WAYS-1:0][ADDR_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]   age;
    } cache_st_t;

    cache_st_t        st_d, st_q;
    logic [SET_W-1:0] idx;
    logic             hit_any;
    logic [AGE_W-1:0] hit_way, victim, sel;
    logic [AGE_W-1:0] sel_age;

    always_comb begin
        st_d    = st_q;
        idx     = SET_W'(acc_addr % SETS);
        hit_any = 1'b0;
        hit_way = '0;
        victim  = '0;
        // parallel tag comparison across the selected set
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.vld[idx][w] && (st_q.tag[idx][w] == acc_addr)) begin
                hit_any = 1'b1;
                hit_way = AGE_W'(w);
            end
            if (st_q.age[idx][w] == AGE_W'(WAYS - 1)) begin
                victim = AGE_W'(w);
            end
        end
        sel     = hit_any ? hit_way : victim;
        sel_age = st_q.age[idx][sel];
        if (acc_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q.age[idx][w] < sel_age) begin
                    st_d.age[idx][w] = st_q.age[idx][w] + 1'b1;
                end
            end
            st_d.age[idx][sel] = '0;
            st_d.vld[idx][sel] = 1'b1;
            st_d.tag[idx][sel] = acc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.vld[s][w] <= 1'b0;
                    st_q.tag[s][w] <= '0;
                    st_q.age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = hit_any;
endmodule

// File: rtl/mc_seen_map.sv
// One bit per block address; set on the first reference.
module mc_seen_map #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mark_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              seen
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (mark_en) begin
            map_d[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign seen = map_q[addr];
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier
    import mc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int BLOCKS = 4,
    parameter int WAYS   = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_stb,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              res_hit,
    output logic              res_miss,
    output logic [1:0]        res_type,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_comp,
    output logic [CNT_W-1:0]  cnt_cap,
    output logic [CNT_W-1:0]  cnt_conf
);
    localparam int SETS = BLOCKS / WAYS;

    typedef struct packed {
        logic             hit;
        logic             miss;
        miss_kind_e       kind;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] comp;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] conf;
    } result_t;

    logic    main_hit, shadow_hit, addr_seen;
    result_t res_d, res_q;

    mc_set_cache #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS)) u_main (
        .clk(clk), .rst(rst), .acc_en(ref_stb), .acc_addr(ref_addr), .hit(main_hit)
    );

    mc_set_cache #(.ADDR_W(ADDR_W), .WAYS(BLOCKS), .SETS(1)) u_shadow (
        .clk(clk), .rst(rst), .acc_en(ref_stb), .acc_addr(ref_addr), .hit(shadow_hit)
    );

    mc_seen_map #(.ADDR_W(ADDR_W)) u_seen (
        .clk(clk), .rst(rst), .mark_en(ref_stb), .addr(ref_addr), .seen(addr_seen)
    );

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    always_comb begin
        res_d      = res_q;
        res_d.hit  = 1'b0;
        res_d.miss = 1'b0;
        res_d.kind = MT_NONE;
        if (ref_stb) begin
            if (main_hit) begin
                res_d.hit = 1'b1;
            end else begin
                res_d.miss  = 1'b1;
                res_d.total = sat_inc(res_q.total);
                if (!addr_seen) begin
                    res_d.kind = MT_COMP;
                    res_d.comp = sat_inc(res_q.comp);
                end else if (shadow_hit) begin
                    res_d.kind = MT_CONF;
                    res_d.conf = sat_inc(res_q.conf);
                end else begin
                    res_d.kind = MT_CAP;
                    res_d.cap  = sat_inc(res_q.cap);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_hit   = res_q.hit;
    assign res_miss  = res_q.miss;
    assign res_type  = res_q.kind;
    assign cnt_total = res_q.total;
    assign cnt_comp  = res_q.comp;
    assign cnt_cap   = res_q.cap;
    assign cnt_conf  = res_q.conf;
endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_stb,
    input logic             res_hit,
    input logic             res_miss,
    input logic [1:0]       res_type,
    input logic [CNT_W-1:0] cnt_total,
    input logic [CNT_W-1:0] cnt_comp,
    input logic [CNT_W-1:0] cnt_cap,
    input logic [CNT_W-1:0] cnt_conf
);
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(res_hit && res_miss)); // R3
    AST_HIT_NO_TYPE: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> res_type == 2'b00); // R3
    AST_MISS_HAS_TYPE: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> res_type != 2'b00); // R5
    AST_RESULT_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        ($past(ref_stb) && !$past(rst)) |-> (res_hit || res_miss)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(ref_stb) |-> (!res_hit && !res_miss && res_type == 2'b00)); // R8
    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
        res_miss |-> (cnt_total == $past(cnt_total) + 1'b1 || $past(cnt_total) == {CNT_W{1'b1}})); // R9
    AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_miss |-> $stable(cnt_total)); // R9
    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cnt_total != {CNT_W{1'b1}}) |->
        ({2'b00, cnt_comp} + {2'b00, cnt_cap} + {2'b00, cnt_conf} == {2'b00, cnt_total})); // R9
endmodule

bind miss_classifier miss_classifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .res_hit(res_hit), .res_miss(res_miss),
    .res_type(res_type), .cnt_total(cnt_total), .cnt_comp(cnt_comp),
    .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
);

// File: tb/sim_miss_classifier.sv
`timescale 1ns/1ps
module sim_miss_classifier;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_stb = 1'b0;
    logic [7:0] ref_addr = '0;

    logic        hit_o  [3];
    logic        miss_o [3];
    logic [1:0]  type_o [3];
    logic [15:0] tot_o  [3];
    logic [15:0] comp_o [3];
    logic [15:0] cap_o  [3];
    logic [15:0] conf_o [3];

    int errors = 0;
    int checks = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    // instance 0: 2-way, 1: direct-mapped, 2: fully associative
    miss_classifier #(.WAYS(2)) u0 (.clk(clk), .rst(rst), .ref_stb(ref_stb), .ref_addr(ref_addr),
        .res_hit(hit_o[0]), .res_miss(miss_o[0]), .res_type(type_o[0]), .cnt_total(tot_o[0]),
        .cnt_comp(comp_o[0]), .cnt_cap(cap_o[0]), .cnt_conf(conf_o[0]));
    miss_classifier #(.WAYS(1)) u_dm (.clk(clk), .rst(rst), .ref_stb(ref_stb), .ref_addr(ref_addr),
        .res_hit(hit_o[1]), .res_miss(miss_o[1]), .res_type(type_o[1]), .cnt_total(tot_o[1]),
        .cnt_comp(comp_o[1]), .cnt_cap(cap_o[1]), .cnt_conf(conf_o[1]));
    miss_classifier #(.WAYS(4)) u_fa (.clk(clk), .rst(rst), .ref_stb(ref_stb), .ref_addr(ref_addr),
        .res_hit(hit_o[2]), .res_miss(miss_o[2]), .res_type(type_o[2]), .cnt_total(tot_o[2]),
        .cnt_comp(comp_o[2]), .cnt_cap(cap_o[2]), .cnt_conf(conf_o[2]));

    // behavioural reference model: LRU lists, most recent first
    int mq [3][4][$];
    int sq [3][$];
    bit seen [3][256];
    bit e_hit [3];
    bit e_miss [3];
    int e_type [3];
    int e_cnt [3][4]; // total, comp, cap, conf
    bit armed = 1'b0;

    function automatic int ways_of(int i);
        return (i == 0) ? 2 : ((i == 1) ? 1 : 4);
    endfunction

    function automatic string kind_tag(bit h, int t);
        if (h) return "R3";
        if (t == 1) return "R5";
        if (t == 2) return "R7";
        if (t == 3) return "R6";
        return "R8";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) begin
            for (int s = 0; s < 4; s++) mq[i][s].delete();
            sq[i].delete();
            for (int a = 0; a < 256; a++) seen[i][a] = 1'b0;
            for (int c = 0; c < 4; c++) e_cnt[i][c] = 0;
            e_hit[i] = 1'b0; e_miss[i] = 1'b0; e_type[i] = 0;
        end
    endtask

    task automatic bump(int i, int c);
        if (e_cnt[i][c] < 65535) e_cnt[i][c]++;
    endtask

    task automatic model_step(int i, bit stb, int a);
        int w, sets, s, mi, si;
        e_hit[i] = 1'b0; e_miss[i] = 1'b0; e_type[i] = 0;
        if (!stb) return;
        w = ways_of(i); sets = 4 / w; s = a % sets;
        mi = -1; si = -1;
        for (int k = 0; k < mq[i][s].size(); k++) if (mq[i][s][k] == a) mi = k;
        for (int k = 0; k < sq[i].size(); k++) if (sq[i][k] == a) si = k;
        if (mi >= 0) begin
            e_hit[i] = 1'b1;
            mq[i][s].delete(mi);
        end else begin
            e_miss[i] = 1'b1;
            bump(i, 0);
            if (!seen[i][a]) begin e_type[i] = 1; bump(i, 1); end
            else if (si >= 0) begin e_type[i] = 3; bump(i, 3); end
            else begin e_type[i] = 2; bump(i, 2); end
            if (mq[i][s].size() == w) void'(mq[i][s].pop_back());
        end
        mq[i][s].push_front(a);
        if (si >= 0) sq[i].delete(si);
        else if (sq[i].size() == 4) void'(sq[i].pop_back());
        sq[i].push_front(a);
        seen[i][a] = 1'b1;
    endtask

    task automatic compare();
        for (int i = 0; i < 3; i++) begin
            string tg;
            tg = {phase, "/", kind_tag(e_hit[i], e_type[i])};
            check(hit_o[i] == e_hit[i] && miss_o[i] == e_miss[i] && int'(type_o[i]) == e_type[i],
                  tg, $sformatf("inst%0d hit/miss/type", i),
                  {hit_o[i], miss_o[i], type_o[i]}, {e_hit[i], e_miss[i], 2'(e_type[i])});
            check(int'(tot_o[i]) == e_cnt[i][0] && int'(comp_o[i]) == e_cnt[i][1] &&
                  int'(cap_o[i]) == e_cnt[i][2] && int'(conf_o[i]) == e_cnt[i][3],
                  {phase, "/R9"}, $sformatf("inst%0d total(comp)", i),
                  int'(tot_o[i]) * 100000 + int'(comp_o[i]), e_cnt[i][0] * 100000 + e_cnt[i][1]);
        end
    endtask

    task automatic cycle(bit stb, int a);
        @(negedge clk);
        if (armed) compare();
        ref_stb  = stb;
        ref_addr = 8'(a);
        for (int i = 0; i < 3; i++) model_step(i, stb, a);
        armed = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        ref_stb = 1'b0;
        rst = 1'b1;
        armed = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        armed = 1'b1;
        phase = "R1";
    endtask

    task automatic refs(int list[$]);
        foreach (list[k]) cycle(1'b1, list[k]);
        cycle(1'b0, 0);
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        cycle(1'b0, 0); // R1: reset state compared here

        phase = "R10";
        refs('{0, 8, 0, 6, 8});
        check(tot_o[1] == 5 && comp_o[1] == 3 && conf_o[1] == 2, "R10", "direct total", tot_o[1], 5);
        check(tot_o[0] == 4 && comp_o[0] == 3 && conf_o[0] == 1, "R10", "2-way total", tot_o[0], 4);
        check(tot_o[2] == 3 && comp_o[2] == 3 && conf_o[2] == 0, "R10", "full total", tot_o[2], 3);

        phase = "R8";
        repeat (3) cycle(1'b0, 0);

        do_reset();
        cycle(1'b0, 0);
        check(tot_o[0] == 0 && tot_o[1] == 0 && tot_o[2] == 0, "R1", "counters after reset", tot_o[0], 0);

        phase = "R2";
        refs('{1, 5, 1, 2, 3, 5, 2, 9, 13});
        phase = "R3";
        refs('{7, 7, 7, 2, 7, 2});
        phase = "R4";
        do_reset();
        refs('{0, 2, 0, 4, 2, 0, 4});
        phase = "R6";
        refs('{16, 20, 16, 20, 24, 16});
        phase = "R7";
        refs('{30, 31, 32, 33, 34, 30, 31, 32, 33, 34});
        phase = "R8";
        for (int k = 0; k < 40; k++) cycle(k % 3 != 0, (k * 37) % 11);
        cycle(1'b0, 0);

        phase = "R9";
        do_reset();
        for (int k = 0; k < 66000; k++) cycle(1'b1, k % 5);
        cycle(1'b0, 0);
        check(tot_o[2] == 16'hFFFF, "R9", "full saturated total", tot_o[2], 65535);
        check(cap_o[2] == 16'hFFFF, "R9", "full saturated capacity", cap_o[2], 65535);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule